// File: doc/BRIEF.md
# Serial Command Decoder with Register Bank

This block is the slave side of a four-wire serial port for a data converter front end. A host lowers chip select, toggles the serial clock and shifts command bytes in on the data input line. Each byte is decoded as an opcode, as the count byte of a burst, or as burst payload. Single-byte opcodes become one-cycle strobes for the neighbouring calibration, power, sync and reset logic. Burst opcodes write or read a bank of sixteen byte-wide registers starting at an address carried in the opcode.

The converter core delivers each new 24-bit result through a load pulse. The result appears in three read-only registers at the top of the bank. All serial inputs are brought into the system clock domain through synchronizer chains, and serial clock edges are detected there. Read data leaves on the data output line with an output enable that is high only while a read burst is running. The bit order of that output can be set to most or least significant bit first by a control-register flag.

Top module: `spi_cmd_regfile`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges while chip select is low, always most significant bit first, and every eight rising edges form one byte.
- R2: Opcode 0101aaaa starts a write burst at address aaaa. The low nibble n of the next byte gives n+1 payload bytes, written to ascending addresses.
- R3: Each single-byte opcode raises exactly one strobe for one system clock cycle: 0x0F stop-continuous, 0xF0 self offset+gain calibration, 0xF2 self gain calibration, 0xF3 system offset calibration, 0xF4 system gain calibration, 0xFB wakeup, 0xFC sync, 0xFD sleep, 0xFE soft reset. Any other non-burst opcode raises nothing.
- R4: Opcode 0001aaaa followed by a count byte with low nibble n shifts out n+1 registers in ascending address order. Output bits change after falling serial-clock edges, so each bit is valid at the following rising edge.
- R5: When bit 3 of register 0x02 is 1, output bytes are sent least significant bit first; when it is 0, most significant bit first. Input order is unaffected.
- R6: After power-up reset and after the 0xFE command, register 0x0A holds 0x59, registers 0x0B and 0x0C hold 0x55, and every other register holds 0x00.
- R7: Registers 0x0D, 0x0E and 0x0F hold the result, most significant byte at 0x0D. They load on the result-load pulse, and burst writes to them have no effect.
- R8: Bit 7 of register 0x02 always reads the live data-ready input. Writes to that bit have no effect.
- R9: Chip select high discards any partial byte or burst and turns the output enable off. The next byte after chip select falls is an opcode. Several commands may follow one another in a single low period.
- R10: Each read byte is captured from its register when the byte's first bit is presented. A result load during that byte changes only the later bytes of the burst.
- R11: Burst addresses advance modulo 16, so a burst that passes 0x0F continues at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo, high during a read burst |
| drdy_i | input | 1 | Live data-ready status from the converter |
| res_load | input | 1 | One-cycle pulse that loads res_data |
| res_data | input | 24 | Conversion result |
| cfg_regs | output | 128 | All sixteen registers, register k at bits 8k+7..8k |
| stb_stop_cont | output | 1 | Stop-continuous strobe |
| stb_cal_self | output | 1 | Self offset and gain calibration strobe |
| stb_cal_self_gain | output | 1 | Self gain calibration strobe |
| stb_cal_sys_off | output | 1 | System offset calibration strobe |
| stb_cal_sys_gain | output | 1 | System gain calibration strobe |
| stb_wake | output | 1 | Wakeup strobe |
| stb_sync | output | 1 | Filter sync strobe |
| stb_sleep | output | 1 | Sleep strobe |
| stb_soft_rst | output | 1 | Soft reset strobe; the register bank is also restored |

## Verification
A result-load pulse from the converter and the capture of a read byte for the serial output can fall in the same clock cycle. In that case the captured byte must come from one consistent register state. The bench provokes this by pulsing the result load partway through the first byte of a read burst over the three result registers. It then requires the old most significant byte followed by the two new lower bytes. A second overlap is a chip-select rise during a partly received write burst. It is judged by reading the target register back unchanged and by seeing the next opcode decoded normally.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   localparam int BYTE_W  = 8;
   localparam int NUM_STB = 9;

   // strobe indices
   localparam int S_STOPC = 0;
   localparam int S_SCAL  = 1;
   localparam int S_SGCAL = 2;
   localparam int S_YOCAL = 3;
   localparam int S_YGCAL = 4;
   localparam int S_WAKE  = 5;
   localparam int S_SYNC  = 6;
   localparam int S_SLEEP = 7;
   localparam int S_SRST  = 8;

   localparam logic [3:0] OPC_WR_HI = 4'h5;
   localparam logic [3:0] OPC_RD_HI = 4'h1;

   typedef enum logic [1:0] {
      PH_OPC,
      PH_CNT,
      PH_WR,
      PH_RD
   } phase_e;

   function automatic logic [NUM_STB-1:0] stb_decode(input logic [BYTE_W-1:0] op);
      logic [NUM_STB-1:0] v;
      v = '0;
      case (op)
         8'h0F: v[S_STOPC] = 1'b1;
         8'hF0: v[S_SCAL]  = 1'b1;
         8'hF2: v[S_SGCAL] = 1'b1;
         8'hF3: v[S_YOCAL] = 1'b1;
         8'hF4: v[S_YGCAL] = 1'b1;
         8'hFB: v[S_WAKE]  = 1'b1;
         8'hFC: v[S_SYNC]  = 1'b1;
         8'hFD: v[S_SLEEP] = 1'b1;
         8'hFE: v[S_SRST]  = 1'b1;
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic logic [BYTE_W-1:0] reg_init(input int idx);
      case (idx)
         10:      return 8'h59;
         11, 12:  return 8'h55;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int   WIDTH   = 3,
   parameter int   STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cmd_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
   import spi_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              din_s,
   output logic              fall,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic [2:0]        bit_idx
);

   logic              sclk_d;
   logic              rise;
   logic [BYTE_W-2:0] shreg;

   assign rise      = ~cs_s & sclk_s & ~sclk_d;
   assign fall      = ~cs_s & ~sclk_s & sclk_d;
   assign byte_done = rise & (bit_idx == 3'd7);
   assign rx_byte   = {shreg, din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         shreg   <= '0;
         bit_idx <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (cs_s) begin
            bit_idx <= '0;
         end else if (rise) begin
            shreg   <= {shreg[BYTE_W-3:0], din_s};
            bit_idx <= bit_idx + 3'd1;
         end
      end
   end

endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int RES_BYTES = 3,
   parameter int ACR_ADDR  = 2,
   parameter int DRDY_BIT  = 7,
   localparam int NUM_REGS = 1 << ADDR_W,
   localparam int RES_BASE = NUM_REGS - RES_BYTES
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [BYTE_W-1:0]            wr_data,
   input  logic                         res_load,
   input  logic [RES_BYTES*BYTE_W-1:0]  res_data,
   input  logic                         drdy,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [BYTE_W-1:0]            rd_data,
   output logic [NUM_REGS*BYTE_W-1:0]   regs_flat
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [BYTE_W-1:0] q;
      if (i >= RES_BASE) begin : g_res
         localparam int SLICE = (RES_BYTES - 1 - (i - RES_BASE)) * BYTE_W;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (soft_rst) q <= '0;
            else if (res_load) q <= res_data[SLICE +: BYTE_W];
         end
      end else begin : g_cfg
         localparam logic [BYTE_W-1:0] INIT  = reg_init(i);
         localparam logic [BYTE_W-1:0] WMASK =
            (i == ACR_ADDR) ? ~(8'h01 << DRDY_BIT) : 8'hFF;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= INIT;
            else if (soft_rst) q <= INIT;
            else if (wr_en && (wr_addr == ADDR_W'(i))) q <= wr_data & WMASK;
         end
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_data = regs_flat[{rd_addr, 3'b000} +: BYTE_W];
      if (rd_addr == ADDR_W'(ACR_ADDR)) rd_data[DRDY_BIT] = drdy;
   end

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_s,
   input  logic               fall,
   input  logic               byte_done,
   input  logic [BYTE_W-1:0]  rx_byte,
   input  logic [2:0]         bit_idx,
   input  logic               lsb_first,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic               wr_en,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0]  wr_data,
   output logic [NUM_STB-1:0] stb,
   output logic               sdo,
   output logic               sdo_oe
);

   phase_e            phase;
   logic              is_read;
   logic [ADDR_W-1:0] addr;
   logic [3:0]        remain;
   logic [BYTE_W-1:0] tx_q;
   logic [2:0]        tx_sel;

   assign wr_en   = byte_done & (phase == PH_WR);
   assign wr_addr = addr;
   assign wr_data = rx_byte;
   assign rd_addr = (phase == PH_RD) ? addr + ADDR_W'(1) : addr;
   assign tx_sel  = lsb_first ? bit_idx : 3'd7 - bit_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_OPC;
         is_read <= 1'b0;
         addr    <= '0;
         remain  <= '0;
         tx_q    <= '0;
         sdo_oe  <= 1'b0;
         stb     <= '0;
      end else begin
         stb <= '0;
         if (cs_s) begin
            phase  <= PH_OPC;
            sdo_oe <= 1'b0;
         end else if (byte_done) begin
            case (phase)
               PH_OPC: begin
                  if (rx_byte[7:4] == OPC_WR_HI || rx_byte[7:4] == OPC_RD_HI) begin
                     is_read <= (rx_byte[7:4] == OPC_RD_HI);
                     addr    <= rx_byte[ADDR_W-1:0];
                     phase   <= PH_CNT;
                  end else begin
                     stb <= stb_decode(rx_byte);
                  end
               end
               PH_CNT: begin
                  remain <= rx_byte[3:0];
                  if (is_read) begin
                     phase  <= PH_RD;
                     tx_q   <= rd_data;
                     sdo_oe <= 1'b1;
                  end else begin
                     phase <= PH_WR;
                  end
               end
               PH_WR: begin
                  addr <= addr + ADDR_W'(1);
                  if (remain == 4'd0) phase <= PH_OPC;
                  else                remain <= remain - 4'd1;
               end
               PH_RD: begin
                  if (remain == 4'd0) begin
                     phase  <= PH_OPC;
                     sdo_oe <= 1'b0;
                  end else begin
                     remain <= remain - 4'd1;
                     addr   <= addr + ADDR_W'(1);
                     tx_q   <= rd_data;
                  end
               end
               default: phase <= PH_OPC;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sdo <= 1'b0;
      else if (fall && sdo_oe) sdo <= tx_q[tx_sel];
   end

endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int RES_BYTES   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ACR_ADDR    = 2,
   parameter int ORDER_BIT   = 3,
   parameter int DRDY_BIT    = 7,
   localparam int NUM_REGS   = 1 << ADDR_W,
   localparam int REG_BITS   = NUM_REGS * BYTE_W,
   localparam int RES_W      = RES_BYTES * BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                sclk,
   input  logic                sdi,
   output logic                sdo,
   output logic                sdo_oe,
   input  logic                drdy_i,
   input  logic                res_load,
   input  logic [RES_W-1:0]    res_data,
   output logic [REG_BITS-1:0] cfg_regs,
   output logic                stb_stop_cont,
   output logic                stb_cal_self,
   output logic                stb_cal_self_gain,
   output logic                stb_cal_sys_off,
   output logic                stb_cal_sys_gain,
   output logic                stb_wake,
   output logic                stb_sync,
   output logic                stb_sleep,
   output logic                stb_soft_rst
);

   if (ADDR_W < 2 || ADDR_W > 4) begin : g_bad_addr
      $error("spi_cmd_regfile: ADDR_W must be 2..4 to fit the opcode nibble");
   end
   if (RES_BYTES < 1 || RES_BYTES >= NUM_REGS - ACR_ADDR) begin : g_bad_res
      $error("spi_cmd_regfile: result bytes overlap the control register");
   end
   if (ORDER_BIT >= BYTE_W || DRDY_BIT >= BYTE_W || ORDER_BIT == DRDY_BIT) begin : g_bad_bits
      $error("spi_cmd_regfile: flag bit positions invalid");
   end

   logic [2:0]         s_q;
   logic               cs_s, sclk_s, din_s;
   logic               fall, byte_done;
   logic [BYTE_W-1:0]  rx_byte, rd_data, wr_data;
   logic [2:0]         bit_idx;
   logic [ADDR_W-1:0]  rd_addr, wr_addr;
   logic               wr_en;
   logic [NUM_STB-1:0] stb_vec;

   spi_cmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({cs_n, sclk, sdi}),
      .q_sync  (s_q)
   );
   assign {cs_s, sclk_s, din_s} = s_q;

   spi_cmd_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sclk_s    (sclk_s),
      .din_s     (din_s),
      .fall      (fall),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .bit_idx   (bit_idx)
   );

   spi_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .fall      (fall),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .bit_idx   (bit_idx),
      .lsb_first (cfg_regs[ACR_ADDR*BYTE_W + ORDER_BIT]),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .stb       (stb_vec),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe)
   );

   spi_cmd_regbank #(
      .ADDR_W(ADDR_W), .RES_BYTES(RES_BYTES),
      .ACR_ADDR(ACR_ADDR), .DRDY_BIT(DRDY_BIT)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (stb_vec[S_SRST]),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .res_load  (res_load),
      .res_data  (res_data),
      .drdy      (drdy_i),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .regs_flat (cfg_regs)
   );

   assign stb_stop_cont     = stb_vec[S_STOPC];
   assign stb_cal_self      = stb_vec[S_SCAL];
   assign stb_cal_self_gain = stb_vec[S_SGCAL];
   assign stb_cal_sys_off   = stb_vec[S_YOCAL];
   assign stb_cal_sys_gain  = stb_vec[S_YGCAL];
   assign stb_wake          = stb_vec[S_WAKE];
   assign stb_sync          = stb_vec[S_SYNC];
   assign stb_sleep         = stb_vec[S_SLEEP];
   assign stb_soft_rst      = stb_vec[S_SRST];

endmodule

// File: rtl/spi_cmd_regfile_chk.sv
module spi_cmd_regfile_chk
   import spi_cmd_pkg::*;
#(
   parameter int RES_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_s,
   input logic               sdo_oe,
   input logic               wr_en,
   input logic               res_load,
   input logic [NUM_STB-1:0] stb_vec,
   input logic [RES_W-1:0]   res_q,
   input logic [BYTE_W-1:0]  fs_lo_q
);

   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_vec)); // R3

   AST_CS_KILLS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdo_oe); // R9

   AST_RESULT_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_q != $past(res_q)) |-> ($past(res_load) || $past(stb_vec[S_SRST]))); // R7

   AST_SOFT_RST_FS: assert property (@(posedge clk) disable iff (!rst_n)
      stb_vec[S_SRST] |=> (fs_lo_q == 8'h59)); // R6

   AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !wr_en); // R2

endmodule

bind spi_cmd_regfile spi_cmd_regfile_chk #(.RES_W(RES_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_s     (cs_s),
   .sdo_oe   (sdo_oe),
   .wr_en    (wr_en),
   .res_load (res_load),
   .stb_vec  (stb_vec),
   .res_q    (cfg_regs[REG_BITS-1 -: RES_W]),
   .fs_lo_q  (cfg_regs[10*8 +: 8])
);

// File: tb/spi_cmd_regfile_bench.sv
module spi_cmd_regfile_bench;

   localparam int HALF = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         sdi = 1'b0;
   logic         sdo, sdo_oe;
   logic         drdy_i = 1'b0;
   logic         res_load = 1'b0;
   logic [23:0]  res_data = '0;
   logic [127:0] cfg_regs;
   logic [8:0]   stb;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   logic [7:0] rbuf [16];
   int         mid_bit = -1;
   logic [23:0] mid_val = '0;

   always #2.5 clk = ~clk;

   spi_cmd_regfile u_spi_cmd_regfile (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .drdy_i(drdy_i), .res_load(res_load),
      .res_data(res_data), .cfg_regs(cfg_regs),
      .stb_stop_cont(stb[0]), .stb_cal_self(stb[1]), .stb_cal_self_gain(stb[2]),
      .stb_cal_sys_off(stb[3]), .stb_cal_sys_gain(stb[4]), .stb_wake(stb[5]),
      .stb_sync(stb[6]), .stb_sleep(stb[7]), .stb_soft_rst(stb[8])
   );

   task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   // monitor: pops expected strobe index whenever a strobe fires
   always @(negedge clk) begin
      if (rst_n && stb != 9'd0) begin
         checks++;
         if ($countones(stb) != 1 || exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3: actual strobes %b expected %0d pending", stb, exp_q.size());
            if (exp_q.size() != 0) void'(exp_q.pop_front());
         end else begin
            int e;
            e = exp_q.pop_front();
            if (stb != (9'd1 << e)) begin
               errors++;
               $display("FAIL R3: actual strobes %b expected index %0d", stb, e);
            end
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      rx = '0;
      for (int i = 0; i < 8; i++) begin
         sdi = tx[7-i];
         if (i == mid_bit) begin
            res_data = mid_val; res_load = 1'b1;
            wait_clk(1);
            res_load = 1'b0;
            wait_clk(HALF - 1);
            mid_bit = -1;
         end else begin
            wait_clk(HALF);
         end
         rx = {rx[6:0], sdo};
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] d;
      spi_byte(b, d);
   endtask

   task automatic cs_lo();
      cs_n = 1'b0; wait_clk(6);
   endtask

   task automatic cs_hi();
      wait_clk(10); cs_n = 1'b1; wait_clk(10);
   endtask

   task automatic cmd(input logic [7:0] op, input int idx);
      exp_q.push_back(idx);
      send(op);
   endtask

   task automatic wr_burst(input logic [3:0] a, input int n, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2);
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      send({4'h5, a});
      send({4'h0, 4'(n - 1)});
      for (int k = 0; k < n; k++) send(d[k]);
   endtask

   task automatic rd_burst(input logic [3:0] a, input int n);
      send({4'h1, a});
      send({4'h0, 4'(n - 1)});
      for (int k = 0; k < n; k++) spi_byte(8'h00, rbuf[k]);
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = v[7-k];
      return r;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] exp_regs;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R6 reset image
      exp_regs = '0;
      exp_regs[10*8 +: 8] = 8'h59;
      exp_regs[11*8 +: 8] = 8'h55;
      exp_regs[12*8 +: 8] = 8'h55;
      check("R6 reset image", cfg_regs, exp_regs);
      check("R9 oe idle", sdo_oe, 0);

      // R4/R6 read full-scale bytes, R1 framing
      cs_lo();
      rd_burst(4'hA, 3);
      check("R4 read 0x0A", rbuf[0], 8'h59);
      check("R4 read 0x0B", rbuf[1], 8'h55);
      check("R4 read 0x0C", rbuf[2], 8'h55);
      check("R4 oe off after burst", sdo_oe, 0);

      // R2 write burst, R9 3-wire back-to-back in same low period
      wr_burst(4'h4, 3, 8'hA1, 8'hB2, 8'hC3);
      rd_burst(4'h4, 3);
      check("R2 rb 0x04", rbuf[0], 8'hA1);
      check("R2 rb 0x05", rbuf[1], 8'hB2);
      check("R2 rb 0x06", rbuf[2], 8'hC3);
      check("R1 port 0x05", cfg_regs[5*8 +: 8], 8'hB2);

      // R7 result load and ignored writes
      res_data = 24'h123456; @(negedge clk) res_load = 1'b1;
      @(negedge clk) res_load = 1'b0;
      wr_burst(4'hD, 3, 8'hFF, 8'hFF, 8'hFF);
      rd_burst(4'hD, 3);
      check("R7 res ms", rbuf[0], 8'h12);
      check("R7 res mid", rbuf[1], 8'h34);
      check("R7 res ls", rbuf[2], 8'h56);

      // R8 data-ready bit live, not writable
      wr_burst(4'h2, 1, 8'h80, 8'h00, 8'h00);
      drdy_i = 1'b0;
      rd_burst(4'h2, 1);
      check("R8 drdy low", rbuf[0], 8'h00);
      drdy_i = 1'b1;
      rd_burst(4'h2, 1);
      check("R8 drdy high", rbuf[0], 8'h80);
      drdy_i = 1'b0;

      // R5 LSB-first output
      wr_burst(4'h2, 1, 8'h08, 8'h00, 8'h00);
      rd_burst(4'hA, 1);
      check("R5 lsb first", rbuf[0], rev8(8'h59));
      wr_burst(4'h2, 1, 8'h00, 8'h00, 8'h00);
      rd_burst(4'hA, 1);
      check("R5 msb first again", rbuf[0], 8'h59);

      // R11 address wrap
      wr_burst(4'hF, 2, 8'hEE, 8'h3C, 8'h00);
      check("R11 wrap to 0x00", cfg_regs[0 +: 8], 8'h3C);
      check("R11 0x0F unchanged", cfg_regs[15*8 +: 8], 8'h56);

      // R10 result update during first byte of a read
      res_data = 24'hAABBCC; @(negedge clk) res_load = 1'b1;
      @(negedge clk) res_load = 1'b0;
      send(8'h1D); send(8'h02);
      mid_val = 24'h112233; mid_bit = 4;
      for (int k = 0; k < 3; k++) spi_byte(8'h00, rbuf[k]);
      check("R10 byte in flight", rbuf[0], 8'hAA);
      check("R10 later mid", rbuf[1], 8'h22);
      check("R10 later ls", rbuf[2], 8'h33);

      // R3 strobes, unknown opcode, then R6 soft reset
      wr_burst(4'hA, 1, 8'h12, 8'h00, 8'h00);
      cmd(8'h0F, 0); cmd(8'hF0, 1); cmd(8'hF2, 2); cmd(8'hF3, 3);
      cmd(8'hF4, 4); cmd(8'hFB, 5); cmd(8'hFC, 6); cmd(8'hFD, 7);
      send(8'h77);
      send(8'hF1);
      cmd(8'hFE, 8);
      wait_clk(10);
      check("R3 all strobes seen", exp_q.size(), 0);
      check("R6 soft reset image", cfg_regs, exp_regs);
      cs_hi();

      // R9 abort partial write burst
      cs_lo();
      send(8'h54); send(8'h00);
      sdi = 1'b1;
      for (int i = 0; i < 4; i++) begin
         wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
      end
      cs_hi();
      cs_lo();
      rd_burst(4'h4, 1);
      check("R9 abort kept 0x04", rbuf[0], 8'h00);
      // abort a read mid-burst
      send(8'h1A); send(8'h02);
      send(8'h00);
      check("R9 oe during read", sdo_oe, 1);
      cs_hi();
      check("R9 oe after cs", sdo_oe, 0);
      cs_lo();
      cmd(8'hFC, 6);
      wait_clk(10);
      check("R9 opcode after abort", exp_q.size(), 0);
      cs_hi();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule